// File: doc/BRIEF.md
# Oversampled Manchester Line Encoder

This block turns a byte stream into one Manchester-coded serial line. It runs on the chip clock and sends one line chip per clock cycle. Every data bit has a transition in the middle of the bit. A falling edge at mid-bit carries a 0 and a rising edge carries a 1. The chip rate is a fixed multiple of the bit rate, so the bit rate follows from how many chips make up each bit. No separate bit timer is used. The line is held low when nothing is being sent.

There are two symbol widths. Wide mode spends eight chips on each bit, so an 8 MHz chip clock gives a 1 Mbit/s line. Packed mode spends two chips on each bit: each 4-bit nibble selects an 8-chip pattern from a 16-entry table. A packet starts when a byte arrives together with the start strobe. Further bytes follow through a ready/valid handshake. When the next byte is offered in time, its chips follow the previous byte with no gap. When no byte is offered, the line returns low after the current byte and busy falls.

Top module: `mch_line_encoder`

## Requirements
- R1: While reset is held, and after it, the line is low, busy is low and ready is high.
- R2: In wide mode each data bit takes eight chips. A 0 is sent as four high chips then four low chips (chip byte 0xF0). A 1 is sent as four low chips then four high chips (0x0F). Data bits go out MSB first.
- R3: In packed mode each data bit takes two chips: pair 10 for a 0 and pair 01 for a 1. The upper nibble goes first. Nibble 0010 gives chip byte 0xA6 and nibble 1100 gives 0x5A. Chips are sent MSB first.
- R4: When a byte is accepted with the start strobe while idle, busy rises on that clock edge and the line shows the byte's first chip in the very next cycle.
- R5: When a byte is valid during the last chip of the current byte, its first chip follows on the next cycle with no idle chip in between.
- R6: Ready is high while idle and during the last chip of each byte, and low at all other times.
- R7: If no byte is valid during the last chip, the line goes low and busy falls on the next edge.
- R8: While idle, a valid byte without the start strobe is consumed and discarded. The line stays low and busy stays low.
- R9: The mode is taken at the start of a packet. Changing the mode input while busy has no effect on the current packet.
- R10: A start strobe that comes with a byte in the middle of a packet is ignored, and the byte is sent as ordinary data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Chip clock, one line chip per cycle |
| rst_ni | input | 1 | Synchronous active-low reset |
| mode_i | input | 1 | 0 = wide (8 chips/bit), 1 = packed (2 chips/bit) |
| in_data_i | input | 8 | Data byte |
| in_sop_i | input | 1 | Start-of-packet strobe, qualified by valid |
| in_valid_i | input | 1 | Byte valid |
| in_ready_o | output | 1 | Encoder takes the byte on this edge if valid |
| line_o | output | 1 | Manchester-coded line |
| busy_o | output | 1 | A packet is being sent |

## Verification
The bench checks the line at byte boundaries, in both modes. A gap or a repeated chip at a boundary shows up as the line falling out of step with the reference. A mode change in mid-packet, and a start strobe repeated in mid-packet, are both aimed at designs that re-sample these inputs. Such a design would switch chip width or restart the packet. A byte offered without a start strobe while idle checks for an encoder that starts anyway. Dropping valid at the last chip checks that the line goes low on that exact edge, not a chip late or early. The packed lookup is checked against the 0xA6 and 0x5A chip bytes directly.

// File: rtl/mch_pkg.sv
// Shared types for the Manchester line encoder.
// Assumes one chip per clock; mode encodings are used on the top-level port.
package mch_pkg;
    typedef enum logic {
        MODE_WIDE   = 1'b0,
        MODE_PACKED = 1'b1
    } mch_mode_e;
endpackage

// File: rtl/mch_nibble_lut.sv
// Maps one data nibble to its packed-mode chip pattern.
// The 16-entry table is computed at elaboration: MSB-first bits,
// first half of each bit high for a 0, low for a 1.
module mch_nibble_lut #(
    parameter int NIB_BITS = 4,
    parameter int CPB      = 2,
    localparam int NCH     = NIB_BITS * CPB,
    localparam int ENTRIES = 1 << NIB_BITS
) (
    input  logic [NIB_BITS-1:0] nib_i,
    output logic [NCH-1:0]      chips_o
);
    // Builds the chip pattern of one table entry
    function automatic logic [NCH-1:0] build(input int val);
        logic [NCH-1:0] pat;
        pat = '0;
        for (int b = 0; b < NIB_BITS; b++) begin
            for (int c = 0; c < CPB; c++) begin
                if (((val >> (NIB_BITS - 1 - b)) & 1) != 0)
                    pat[NCH - 1 - (b * CPB + c)] = (c >= CPB / 2);
                else
                    pat[NCH - 1 - (b * CPB + c)] = (c < CPB / 2);
            end
        end
        return pat;
    endfunction

    logic [NCH-1:0] tbl [ENTRIES];

    for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
        assign tbl[e] = build(e);
    end

    // Table read
    assign chips_o = tbl[nib_i];
endmodule

// File: rtl/mch_chip_expander.sv
// Expands a data byte into its full chip vector, left-aligned (first chip
// at the MSB). Wide mode uses a fixed per-bit pattern; packed mode uses one
// nibble lookup per nibble, upper nibble first. Assumes wide >= packed width.
module mch_chip_expander
    import mch_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int WIDE_CPB = 8,
    parameter int PACK_CPB = 2,
    parameter int NIB_BITS = 4,
    localparam int WCH     = DATA_W * WIDE_CPB,
    localparam int PCH     = DATA_W * PACK_CPB,
    localparam int NIBS    = DATA_W / NIB_BITS,
    localparam int NIB_CH  = NIB_BITS * PACK_CPB
) (
    input  logic [DATA_W-1:0] data_i,
    input  mch_mode_e         mode_i,
    output logic [WCH-1:0]    chips_o
);
    localparam int HALF = WIDE_CPB / 2;
    localparam logic [WIDE_CPB-1:0] ZERO_PAT = {{HALF{1'b1}}, {(WIDE_CPB - HALF){1'b0}}};
    localparam logic [WIDE_CPB-1:0] ONE_PAT  = ~ZERO_PAT;

    logic [WCH-1:0] wide;
    logic [PCH-1:0] packed_v;

    for (genvar b = 0; b < DATA_W; b++) begin : g_wide
        assign wide[WCH - 1 - b * WIDE_CPB -: WIDE_CPB] =
            data_i[DATA_W - 1 - b] ? ONE_PAT : ZERO_PAT;
    end

    for (genvar n = 0; n < NIBS; n++) begin : g_nib
        mch_nibble_lut #(
            .NIB_BITS (NIB_BITS),
            .CPB      (PACK_CPB)
        ) u_lut (
            .nib_i   (data_i[DATA_W - 1 - n * NIB_BITS -: NIB_BITS]),
            .chips_o (packed_v[PCH - 1 - n * NIB_CH -: NIB_CH])
        );
    end

    // Mode select, packed vector left-aligned
    always_comb begin
        if (mode_i == MODE_PACKED)
            chips_o = WCH'(packed_v) << (WCH - PCH);
        else
            chips_o = wide;
    end
endmodule

// File: rtl/mch_chip_shifter.sv
// Sequences packets: loads a byte's chip vector, shifts one chip per clock,
// and at the last chip either reloads (back-to-back) or goes idle low.
// Assumes the chip vector for the selected mode is present on chips_i.
module mch_chip_shifter
    import mch_pkg::*;
#(
    parameter int WCH  = 64,
    parameter int PCH  = 16,
    localparam int CNT_W = $clog2(WCH)
) (
    input  logic           clk_i,
    input  logic           rst_ni,
    input  mch_mode_e      mode_i,
    input  logic [WCH-1:0] chips_i,
    input  logic           in_sop_i,
    input  logic           in_valid_i,
    output logic           in_ready_o,
    output mch_mode_e      mode_sel_o,
    output mch_mode_e      mode_q_o,
    output logic           line_o,
    output logic           busy_o
);
    logic [WCH-1:0]   sr_q;
    logic [CNT_W-1:0] cnt_q;
    logic             busy_q;
    mch_mode_e        mode_q;
    logic             last, take, start, cont;
    logic [CNT_W-1:0] load_cnt;

    // Handshake and load decisions
    always_comb begin
        last       = (cnt_q == '0);
        in_ready_o = !busy_q || last;
        take       = in_valid_i && in_ready_o;
        start      = take && !busy_q && in_sop_i;
        cont       = take && busy_q;
        mode_sel_o = busy_q ? mode_q : mode_i;
        load_cnt   = (mode_sel_o == MODE_PACKED) ? CNT_W'(PCH - 1) : CNT_W'(WCH - 1);
    end

    // Chip shift register, chip counter and mode latch
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            sr_q   <= '0;
            cnt_q  <= '0;
            busy_q <= 1'b0;
            mode_q <= MODE_WIDE;
        end else if (start || cont) begin
            sr_q   <= chips_i;
            cnt_q  <= load_cnt;
            busy_q <= 1'b1;
            if (start)
                mode_q <= mode_i;
        end else if (busy_q && last) begin
            sr_q   <= '0;
            busy_q <= 1'b0;
        end else if (busy_q) begin
            sr_q  <= sr_q << 1;
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign line_o   = sr_q[WCH-1];
    assign busy_o   = busy_q;
    assign mode_q_o = mode_q;
endmodule

// File: rtl/mch_line_encoder.sv
// Top of the Manchester line encoder: byte stream in, one coded line out.
// Runs on the chip clock; mode is sampled at packet start.
module mch_line_encoder
    import mch_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int WIDE_CPB = 8,
    parameter int PACK_CPB = 2,
    parameter int NIB_BITS = 4
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              mode_i,
    input  logic [DATA_W-1:0] in_data_i,
    input  logic              in_sop_i,
    input  logic              in_valid_i,
    output logic              in_ready_o,
    output logic              line_o,
    output logic              busy_o
);
    localparam int WCH = DATA_W * WIDE_CPB;
    localparam int PCH = DATA_W * PACK_CPB;

    mch_mode_e      mode_in;
    mch_mode_e      mode_sel;
    mch_mode_e      mode_q;
    logic [WCH-1:0] chips;

    assign mode_in = mch_mode_e'(mode_i);

    mch_chip_expander #(
        .DATA_W   (DATA_W),
        .WIDE_CPB (WIDE_CPB),
        .PACK_CPB (PACK_CPB),
        .NIB_BITS (NIB_BITS)
    ) u_expand (
        .data_i  (in_data_i),
        .mode_i  (mode_sel),
        .chips_o (chips)
    );

    mch_chip_shifter #(
        .WCH (WCH),
        .PCH (PCH)
    ) u_shift (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .mode_i     (mode_in),
        .chips_i    (chips),
        .in_sop_i   (in_sop_i),
        .in_valid_i (in_valid_i),
        .in_ready_o (in_ready_o),
        .mode_sel_o (mode_sel),
        .mode_q_o   (mode_q),
        .line_o     (line_o),
        .busy_o     (busy_o)
    );
endmodule

// File: rtl/mch_line_encoder_chk.sv
// Protocol checker for the Manchester line encoder, bound to the top.
module mch_line_encoder_chk (
    input logic clk_i,
    input logic rst_ni,
    input logic in_sop_i,
    input logic in_valid_i,
    input logic in_ready_o,
    input logic line_o,
    input logic busy_o,
    input logic mode_q
);
    AST_IDLE_LINE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !busy_o |-> !line_o); // R7
    AST_START_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!busy_o && in_valid_i && in_sop_i) |=> busy_o); // R4
    AST_IDLE_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !busy_o |-> in_ready_o); // R6
    AST_CONT_NO_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_o && in_ready_o && in_valid_i) |=> busy_o); // R5
    AST_DROP_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_o && in_ready_o && !in_valid_i) |=> (!busy_o && !line_o)); // R7
    AST_NOSOP_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!busy_o && in_valid_i && !in_sop_i) |=> !busy_o); // R8
    AST_MODE_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        busy_o |=> $stable(mode_q)); // R9
endmodule

bind mch_line_encoder mch_line_encoder_chk u_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .in_sop_i   (in_sop_i),
    .in_valid_i (in_valid_i),
    .in_ready_o (in_ready_o),
    .line_o     (line_o),
    .busy_o     (busy_o),
    .mode_q     (mode_q)
);

// File: tb/mch_line_encoder_tb.sv
// Bench: behavioural chip-queue model compared on every clock, plus directed checks.
module mch_line_encoder_tb;
    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic       rst_n = 1'b0;
    logic       in_mode = 1'b0;
    logic [7:0] in_data = '0;
    logic       in_sop = 1'b0;
    logic       in_valid = 1'b0;
    logic       in_ready, line, busy;

    mch_line_encoder u_dut (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .mode_i     (in_mode),
        .in_data_i  (in_data),
        .in_sop_i   (in_sop),
        .in_valid_i (in_valid),
        .in_ready_o (in_ready),
        .line_o     (line),
        .busy_o     (busy)
    );

    int    total = 0;
    int    bad = 0;
    string phase = "R1";
    bit    cmp_en = 1'b0;
    bit    done = 1'b0;

    // Reference model state
    bit   ref_busy = 1'b0;
    bit   ref_line = 1'b0;
    logic ref_mode = 1'b0;
    bit   chq[$];

    function automatic void load_chips(input logic [7:0] d, input logic m);
        int cpb;
        cpb = m ? 2 : 8;
        chq.delete();
        for (int b = 7; b >= 0; b--) begin
            for (int c = 0; c < cpb; c++) begin
                if (d[b]) chq.push_back(c >= cpb / 2);
                else      chq.push_back(c < cpb / 2);
            end
        end
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            ref_busy = 1'b0; ref_line = 1'b0; ref_mode = 1'b0; chq.delete();
        end else if (!ref_busy) begin
            if (in_valid && in_sop) begin
                ref_mode = in_mode;
                load_chips(in_data, in_mode);
                ref_line = chq.pop_front();
                ref_busy = 1'b1;
            end
        end else if (chq.size() == 0) begin
            if (in_valid) begin
                load_chips(in_data, ref_mode);
                ref_line = chq.pop_front();
            end else begin
                ref_busy = 1'b0;
                ref_line = 1'b0;
            end
        end else begin
            ref_line = chq.pop_front();
        end
    end

    task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s act=%0h exp=%0h t=%0t", req, what, act, exp, $time);
        end
    endtask

    // Per-cycle comparison against the model
    always @(negedge clk) begin
        if (cmp_en) begin
            chk(phase, "line", 64'(line), 64'(ref_line));
            chk(phase, "busy", 64'(busy), 64'(ref_busy));
            chk("R6", "ready", 64'(in_ready), 64'(!ref_busy || chq.size() == 0));
        end
    end

    // Offer a byte at a negedge and return at the negedge after it is taken
    task automatic send_byte(input logic [7:0] d, input logic s);
        in_data = d; in_sop = s; in_valid = 1'b1;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic drop_valid();
        in_valid = 1'b0; in_sop = 1'b0;
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic capture(input int n, output logic [63:0] v);
        v = '0;
        for (int i = 0; i < n; i++) begin
            v = {v[62:0], line};
            @(negedge clk);
        end
    endtask

    logic [63:0] cap;

    initial begin
        repeat (3) @(negedge clk);
        chk("R1", "line in reset", 64'(line), 64'd0);
        chk("R1", "busy in reset", 64'(busy), 64'd0);
        chk("R1", "ready in reset", 64'(in_ready), 64'd1);
        rst_n = 1'b1;
        cmp_en = 1'b1;
        @(negedge clk);

        // Wide mode symbols
        phase = "R2";
        in_mode = 1'b0;
        send_byte(8'h00, 1'b1);
        drop_valid();
        chk("R4", "busy after start", 64'(busy), 64'd1);
        chk("R4", "first chip", 64'(line), 64'd1);
        capture(8, cap);
        chk("R2", "wide 0 chips", cap[7:0], 64'hF0);
        wait_idle();
        send_byte(8'h80, 1'b1);
        drop_valid();
        capture(8, cap);
        chk("R2", "wide 1 chips", cap[7:0], 64'h0F);
        wait_idle();

        // Packed mode lookup
        phase = "R3";
        in_mode = 1'b1;
        send_byte(8'h2C, 1'b1);
        drop_valid();
        capture(8, cap);
        chk("R3", "nibble 2 chips", cap[7:0], 64'hA6);
        capture(8, cap);
        chk("R3", "nibble C chips", cap[7:0], 64'h5A);
        chk("R7", "busy after drop", 64'(busy), 64'd0);
        chk("R7", "line after drop", 64'(line), 64'd0);
        wait_idle();

        // Back-to-back, mid-packet mode change and repeated strobe
        phase = "R5";
        in_mode = 1'b0;
        send_byte(8'hA5, 1'b1);
        in_mode = 1'b1;                      // R9: ignored while busy
        send_byte(8'h3C, 1'b1);              // R10: strobe mid-packet ignored
        send_byte(8'hF0, 1'b0);
        drop_valid();
        phase = "R9";
        chk("R9", "still busy wide", 64'(busy), 64'd1);
        wait_idle();

        phase = "R3";
        in_mode = 1'b1;
        send_byte(8'h12, 1'b1);
        send_byte(8'h34, 1'b0);
        in_mode = 1'b0;
        send_byte(8'hAB, 1'b1);
        send_byte(8'hEF, 1'b0);
        drop_valid();
        wait_idle();

        // Byte without strobe while idle
        phase = "R8";
        in_mode = 1'b0;
        send_byte(8'h55, 1'b0);
        drop_valid();
        repeat (4) begin
            chk("R8", "busy stays low", 64'(busy), 64'd0);
            chk("R8", "line stays low", 64'(line), 64'd0);
            @(negedge clk);
        end

        // Random packets
        phase = "R5";
        for (int k = 0; k < 20; k++) begin
            int len;
            in_mode = 1'($urandom);
            len = 1 + int'($urandom % 4);
            for (int j = 0; j < len; j++) begin
                send_byte(8'($urandom), j == 0);
                if ((k % 3) == 0) in_mode = ~in_mode;
            end
            drop_valid();
            wait_idle();
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog R1 act=running exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule